// File: doc/BRIEF.md
# Sleep-Pin Low-Power Mode Controller

This block sits on the device side of an asynchronous pseudo-static memory. It watches an active-low sleep pin together with the chip-enable and write strobes, and it owns the configuration register that decides how the memory behaves while the pin is held low. With the pin low, an ordinary write cycle does not reach the array. Instead, the address lines are captured into the configuration register when the strobe ends. If the pin then stays low beyond a programmable hold time, the controller enters a sleep mode. Bit 4 of the configuration register selects which one: a partial refresh mode that keeps part of the array alive, or a deep power-down that keeps nothing.

A second load path models a software register load. Setting bit 4 over that path starts partial refresh at once. After any software load, the sleep pin can no longer start partial refresh, although it can still load the register and start deep power-down. While any sleep or recovery mode is active, array accesses are refused. Leaving deep power-down runs a recovery timer before access is granted again.

Two probe outputs report, for a given address, whether that address lies in the region currently kept alive, and whether its data survived the most recent low-power episode.

Top module: `slp_lowpower`

## Requirements
- R1: After reset, `mode` is 0 (active) and `cfgOut` is 0x00080, so bit 4 = 0 and deep power-down is selected.
- R2: A write cycle ends on the first cycle in which `ceN` or `weN` is high after a cycle with both low. If `sleepN` is low on that cycle, `cfgOut` takes the `addr` value of the last write cycle, visible one cycle later. If `sleepN` is high, `cfgOut` does not change.
- R3: In mode 0, `sleepN` low on HOLD_CYC+1 consecutive clock edges moves `mode` on the last of them. The new mode is 3 (deep power-down) if `cfgOut[4]`=0, and 1 (pin partial refresh) if `cfgOut[4]`=1 and no software load has occurred since reset. A shorter low period leaves `mode` at 0.
- R4: `accessGrant` is high exactly when `ceN` is low and `mode` is 0. It is low in modes 1 to 4.
- R5: In mode 1, a high `sleepN` returns `mode` to 0 on the next edge.
- R6: In mode 3, a high `sleepN` moves `mode` to 4 (recovery) on the next edge. `mode` then stays 4 for exactly RECOV_CYC cycles before returning to 0.
- R7: Region codes in `cfgOut[2:0]` (k = code[1:0]):
  - 000 keeps the whole array.
  - 100 keeps nothing.
  - Any other code with bit 2 = 0 keeps the lowest 1/2^k of the address space.
  - Any other code with bit 2 = 1 keeps the highest 1/2^k.

  `probeRefreshed` reports whether `probeAddr` is kept. It is 1 in mode 0, follows the code in modes 1 and 2, and is 0 in modes 3 and 4.
- R8: `swWrEn` is honoured only in modes 0 and 2. An honoured load writes `swWrData`, zero-extended, into `cfgOut`. With bit 4 = 1 from mode 0 it moves `mode` to 2 on the next edge; with bit 4 = 0 from mode 2 it returns `mode` to 0. In modes 1, 3 and 4 the load has no effect.
- R9: After any honoured software load, the R3 hold with `cfgOut[4]`=1 leaves `mode` at 0. Pin loads still update `cfgOut`, and a hold with `cfgOut[4]`=0 still enters mode 3.
- R10: In modes 3 and 4, pin write cycles do not change `cfgOut`.
- R11: `probeValid` is 1 for every address until the first sleep entry after reset. Entering mode 3 makes it 0 for every address. Entering mode 1 or 2 makes it equal to R7 region membership under the code in force at entry. It holds that value until the next sleep entry.
- R12: At the edge where `sleepN` is first seen low, `ceN` and `weN` are high, and `weN` is still high one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepN | input | 1 | Active-low sleep pin |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Address lines, used as register data during a pin load |
| swWrEn | input | 1 | Software register load strobe |
| swWrData | input | DATA_W | Software register load value |
| probeAddr | input | ADDR_W | Address under query by the probe outputs |
| mode | output | 3 | 0 active, 1 pin partial refresh, 2 software partial refresh, 3 deep power-down, 4 recovery |
| cfgOut | output | ADDR_W | Configuration register |
| accessGrant | output | 1 | Array access allowed this cycle |
| probeRefreshed | output | 1 | `probeAddr` is in the region currently kept |
| probeValid | output | 1 | Data at `probeAddr` survived the last low-power episode |

## Verification
The checks take for granted the R12 input discipline: the chip is deselected and write enable is idle when the sleep pin falls, and no write strobe follows within one cycle. All inputs are also assumed to be synchronous to `clk`. The stimulus keeps within these limits. Every sleep episode begins with both strobes high, and the pin-load write cycle waits two edges after the fall before it starts. Write cycles used in the deep power-down tests start only after the mode has been entered.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [2:0] {
    MODE_ACTIVE  = 3'd0,
    MODE_PAR_PIN = 3'd1,
    MODE_PAR_SW  = 3'd2,
    MODE_DPD     = 3'd3,
    MODE_RECOVER = 3'd4
  } lpMode_t;

  typedef enum logic [1:0] {
    LOSS_NONE = 2'd0,
    LOSS_PART = 2'd1,
    LOSS_ALL  = 2'd2
  } lossKind_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capAddr;    // write strobe active: track the address
    logic commitPin;  // pin write has ended: load the register
    logic takeSw;     // software load is honoured
    logic markPar;    // partial refresh is being entered
    logic markDpd;    // deep power-down is being entered
  } lpStrobe_t;

endpackage

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int HOLD_CYC  = 2500,
  parameter int RECOV_CYC = 37500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepN,
  input  logic      ceN,
  input  logic      weN,
  input  logic      swWrEn,
  input  logic      swSleepBit,
  input  logic      cfgSleep,
  input  logic      swLoaded,
  output lpMode_t   mode,
  output lpStrobe_t stb
);

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int REC_W  = $clog2(RECOV_CYC + 1);

  logic              wrAct, wrActQ;
  logic              pinPathOpen, swOk, holdDone, recDone;
  logic [HOLD_W-1:0] holdCnt;
  logic [REC_W-1:0]  recCnt;
  lpMode_t           nextMode;

  assign wrAct       = !ceN && !weN;
  assign pinPathOpen = (mode == MODE_ACTIVE) || (mode == MODE_PAR_PIN) || (mode == MODE_PAR_SW);
  assign swOk        = swWrEn && ((mode == MODE_ACTIVE) || (mode == MODE_PAR_SW));
  assign holdDone    = (mode == MODE_ACTIVE) && !sleepN && (holdCnt == HOLD_W'(HOLD_CYC));
  assign recDone     = (recCnt == REC_W'(RECOV_CYC - 1));

  always_comb begin
    nextMode = mode;
    unique case (mode)
      MODE_ACTIVE: begin
        if (swOk && swSleepBit)         nextMode = MODE_PAR_SW;
        else if (holdDone && !cfgSleep) nextMode = MODE_DPD;
        else if (holdDone && !swLoaded) nextMode = MODE_PAR_PIN;
      end
      MODE_PAR_PIN: if (sleepN)                nextMode = MODE_ACTIVE;
      MODE_PAR_SW:  if (swOk && !swSleepBit)   nextMode = MODE_ACTIVE;
      MODE_DPD:     if (sleepN)                nextMode = MODE_RECOVER;
      MODE_RECOVER: if (recDone)               nextMode = MODE_ACTIVE;
      default:                                 nextMode = MODE_ACTIVE;
    endcase
  end

  always_comb begin
    stb.capAddr   = wrAct;
    stb.commitPin = wrActQ && !wrAct && !sleepN && pinPathOpen;
    stb.takeSw    = swOk;
    stb.markPar   = (mode == MODE_ACTIVE) &&
                    ((nextMode == MODE_PAR_PIN) || (nextMode == MODE_PAR_SW));
    stb.markDpd   = (mode == MODE_ACTIVE) && (nextMode == MODE_DPD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_ACTIVE;
      wrActQ  <= 1'b0;
      holdCnt <= '0;
      recCnt  <= '0;
    end else begin
      mode   <= nextMode;
      wrActQ <= wrAct;
      if ((mode == MODE_ACTIVE) && !sleepN) begin
        if (holdCnt != HOLD_W'(HOLD_CYC)) holdCnt <= holdCnt + 1'b1;
      end else begin
        holdCnt <= '0;
      end
      if (mode == MODE_RECOVER) recCnt <= recCnt + 1'b1;
      else                      recCnt <= '0;
    end
  end

endmodule

// File: rtl/slp_dpath.sv
module slp_dpath
  import slp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] swWrData,
  input  logic [ADDR_W-1:0] probeAddr,
  input  lpMode_t           mode,
  input  lpStrobe_t         stb,
  output logic [ADDR_W-1:0] cfgOut,
  output logic              swLoaded,
  output logic              probeRefreshed,
  output logic              probeValid
);

  localparam logic [ADDR_W-1:0] CFG_RESET = ADDR_W'(8'h80);
  localparam logic [ADDR_W:0]   FULL_SPAN = (ADDR_W + 1)'(1) << ADDR_W;

  logic [ADDR_W-1:0] addrHold;
  logic [ADDR_W-1:0] swExt;
  logic [2:0]        keptCode;
  lossKind_t         lossKind;

  assign swExt = ADDR_W'(swWrData);

  function automatic logic regionHit(input logic [2:0] code, input logic [ADDR_W-1:0] a);
    logic [ADDR_W:0] span;
    span = FULL_SPAN >> code[1:0];
    if (code == 3'b000)      return 1'b1;
    else if (code == 3'b100) return 1'b0;
    else if (!code[2])       return {1'b0, a} < span;
    else                     return {1'b0, a} >= (FULL_SPAN - span);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgOut   <= CFG_RESET;
      addrHold <= '0;
      swLoaded <= 1'b0;
      keptCode <= 3'b000;
      lossKind <= LOSS_NONE;
    end else begin
      if (stb.capAddr) addrHold <= addr;
      if (stb.commitPin)   cfgOut <= addrHold;
      else if (stb.takeSw) cfgOut <= swExt;
      if (stb.takeSw) swLoaded <= 1'b1;
      if (stb.markDpd) begin
        lossKind <= LOSS_ALL;
      end else if (stb.markPar) begin
        lossKind <= LOSS_PART;
        keptCode <= stb.takeSw ? swExt[2:0] : cfgOut[2:0];
      end
    end
  end

  always_comb begin
    unique case (mode)
      MODE_ACTIVE:              probeRefreshed = 1'b1;
      MODE_PAR_PIN, MODE_PAR_SW: probeRefreshed = regionHit(cfgOut[2:0], probeAddr);
      default:                  probeRefreshed = 1'b0;
    endcase
    unique case (lossKind)
      LOSS_NONE: probeValid = 1'b1;
      LOSS_PART: probeValid = regionHit(keptCode, probeAddr);
      default:   probeValid = 1'b0;
    endcase
  end

endmodule

// File: rtl/slp_lowpower.sv
module slp_lowpower
  import slp_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int HOLD_CYC  = 2500,
  parameter int RECOV_CYC = 37500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              swWrEn,
  input  logic [DATA_W-1:0] swWrData,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic [2:0]        mode,
  output logic [ADDR_W-1:0] cfgOut,
  output logic              accessGrant,
  output logic              probeRefreshed,
  output logic              probeValid
);

  lpMode_t   curMode;
  lpStrobe_t stb;
  logic      swLoaded;

  slp_ctrl #(
    .HOLD_CYC (HOLD_CYC),
    .RECOV_CYC(RECOV_CYC)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepN    (sleepN),
    .ceN       (ceN),
    .weN       (weN),
    .swWrEn    (swWrEn),
    .swSleepBit(swWrData[4]),
    .cfgSleep  (cfgOut[4]),
    .swLoaded  (swLoaded),
    .mode      (curMode),
    .stb       (stb)
  );

  slp_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .addr          (addr),
    .swWrData      (swWrData),
    .probeAddr     (probeAddr),
    .mode          (curMode),
    .stb           (stb),
    .cfgOut        (cfgOut),
    .swLoaded      (swLoaded),
    .probeRefreshed(probeRefreshed),
    .probeValid    (probeValid)
  );

  assign mode        = curMode;
  assign accessGrant = !ceN && (curMode == MODE_ACTIVE);

endmodule

// File: rtl/slp_lowpower_chk.sv
module slp_lowpower_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleepN,
  input logic              ceN,
  input logic              weN,
  input logic              swWrEn,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] cfgOut,
  input logic              accessGrant,
  input logic              probeRefreshed,
  input logic              probeValid
);

  // R12
  sleep_fall_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepN) |-> (ceN && weN));

  // R12
  sleep_fall_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepN) |=> weN);

  // R3
  active_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd0 && sleepN && !swWrEn) |=> (mode == 3'd0));

  // R5
  par_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd1 && sleepN) |=> (mode == 3'd0));

  // R6
  dpd_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3 && sleepN) |=> (mode == 3'd4));

  // R6
  recover_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd4) |=> (mode == 3'd4 || mode == 3'd0));

  // R10
  dpd_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3 || mode == 3'd4) |=> $stable(cfgOut));

  // R4 and R7
  grant_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessGrant |-> probeRefreshed);

  // R11
  dpd_lost_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3) |-> (!probeValid && !probeRefreshed));

endmodule

bind slp_lowpower slp_lowpower_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .sleepN        (sleepN),
  .ceN           (ceN),
  .weN           (weN),
  .swWrEn        (swWrEn),
  .mode          (mode),
  .cfgOut        (cfgOut),
  .accessGrant   (accessGrant),
  .probeRefreshed(probeRefreshed),
  .probeValid    (probeValid)
);

// File: tb/test_slp_lowpower.sv
`timescale 1ns/1ps
module test_slp_lowpower;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int HOLD   = 8;
  localparam int RECOV  = 20;
  localparam int NVEC   = 14;

  // {code[2:0], probe address[19:0], expected membership}
  localparam logic [23:0] VEC [NVEC] = '{
    {3'b000, 20'hFFFFF, 1'b1},
    {3'b001, 20'h7FFFF, 1'b1},
    {3'b001, 20'h80000, 1'b0},
    {3'b010, 20'h3FFFF, 1'b1},
    {3'b010, 20'h40000, 1'b0},
    {3'b011, 20'h1FFFF, 1'b1},
    {3'b011, 20'h20000, 1'b0},
    {3'b100, 20'h00000, 1'b0},
    {3'b101, 20'h80000, 1'b1},
    {3'b101, 20'h7FFFF, 1'b0},
    {3'b110, 20'hC0000, 1'b1},
    {3'b110, 20'hBFFFF, 1'b0},
    {3'b111, 20'hE0000, 1'b1},
    {3'b111, 20'hDFFFF, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sleepN = 1'b1;
  logic              ceN = 1'b1;
  logic              weN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              swWrEn = 1'b0;
  logic [DATA_W-1:0] swWrData = '0;
  logic [ADDR_W-1:0] probeAddr = '0;
  logic [2:0]        mode;
  logic [ADDR_W-1:0] cfgOut;
  logic              accessGrant;
  logic              probeRefreshed;
  logic              probeValid;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  slp_lowpower #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .HOLD_CYC (HOLD),
    .RECOV_CYC(RECOV)
  ) i_slp_lowpower (
    .clk           (clk),
    .rstN          (rstN),
    .sleepN        (sleepN),
    .ceN           (ceN),
    .weN           (weN),
    .addr          (addr),
    .swWrEn        (swWrEn),
    .swWrData      (swWrData),
    .probeAddr     (probeAddr),
    .mode          (mode),
    .cfgOut        (cfgOut),
    .accessGrant   (accessGrant),
    .probeRefreshed(probeRefreshed),
    .probeValid    (probeValid)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Pin falls, a write cycle loads a, the pin is held low until entry time.
  task automatic pinEpisode(input logic [ADDR_W-1:0] a);
    sleepN = 1'b0;
    step(2);
    ceN = 1'b0; weN = 1'b0; addr = a;
    step(1);
    ceN = 1'b1; weN = 1'b1; addr = '0;
    step(1);
    step(HOLD - 4);
    chk("R3 no entry before hold expires", {29'd0, mode}, 32'd0);
    step(1);
  endtask

  task automatic swLoad(input logic [DATA_W-1:0] d);
    swWrEn = 1'b1; swWrData = d;
    step(1);
    swWrEn = 1'b0; swWrData = '0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 mode", {29'd0, mode}, 32'd0);
    chk("R1 cfg", {12'd0, cfgOut}, 32'h80);
    chk("R7 active keeps all", {31'd0, probeRefreshed}, 32'd1);
    chk("R11 valid before any episode", {31'd0, probeValid}, 32'd1);
    ceN = 1'b0; #1;
    chk("R4 grant in active", {31'd0, accessGrant}, 32'd1);
    ceN = 1'b1; #1;
    chk("R4 no grant deselected", {31'd0, accessGrant}, 32'd0);

    // R2 write with sleep pin high leaves the register alone
    ceN = 1'b0; weN = 1'b0; addr = 20'h00013;
    step(1);
    ceN = 1'b1; weN = 1'b1; addr = '0;
    step(2);
    chk("R2 no load with pin high", {12'd0, cfgOut}, 32'h80);

    // Region table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0]        code;
      logic [ADDR_W-1:0] pa;
      logic              ex;
      code = VEC[i][23:21];
      pa   = VEC[i][20:1];
      ex   = VEC[i][0];
      probeAddr = pa;
      pinEpisode(20'h00090 | ADDR_W'(code));
      chk("R3 partial entry", {29'd0, mode}, 32'd1);
      chk("R2 pin load value", {12'd0, cfgOut}, 32'h90 | 32'(code));
      chk("R7 region membership", {31'd0, probeRefreshed}, {31'd0, ex});
      ceN = 1'b0; #1;
      chk("R4 no grant in partial", {31'd0, accessGrant}, 32'd0);
      ceN = 1'b1;
      sleepN = 1'b1;
      step(1);
      chk("R5 partial exit", {29'd0, mode}, 32'd0);
      chk("R11 retained status", {31'd0, probeValid}, {31'd0, ex});
    end

    // Deep power-down
    probeAddr = 20'h00000;
    pinEpisode(20'h00000);
    chk("R3 deep entry", {29'd0, mode}, 32'd3);
    chk("R11 all lost", {31'd0, probeValid}, 32'd0);
    chk("R7 nothing kept in deep", {31'd0, probeRefreshed}, 32'd0);
    ceN = 1'b0; weN = 1'b0; addr = 20'h00095;
    #1;
    chk("R4 no grant in deep", {31'd0, accessGrant}, 32'd0);
    step(1);
    ceN = 1'b1; weN = 1'b1; addr = '0;
    step(2);
    chk("R10 pin load ignored in deep", {12'd0, cfgOut}, 32'd0);
    swLoad(16'h0011);
    step(1);
    chk("R8 sw load ignored in deep", {12'd0, cfgOut}, 32'd0);
    chk("R8 mode kept in deep", {29'd0, mode}, 32'd3);
    sleepN = 1'b1;
    step(1);
    chk("R6 recovery starts", {29'd0, mode}, 32'd4);
    ceN = 1'b0; #1;
    chk("R4 no grant in recovery", {31'd0, accessGrant}, 32'd0);
    ceN = 1'b1;
    step(RECOV - 1);
    chk("R6 recovery last cycle", {29'd0, mode}, 32'd4);
    step(1);
    chk("R6 recovery done", {29'd0, mode}, 32'd0);
    chk("R11 still lost after recovery", {31'd0, probeValid}, 32'd0);

    // Software path
    probeAddr = 20'hC0000;
    swLoad(16'h0016);
    chk("R8 sw enters partial", {29'd0, mode}, 32'd2);
    chk("R8 sw load value", {12'd0, cfgOut}, 32'h16);
    chk("R7 sw region", {31'd0, probeRefreshed}, 32'd1);
    chk("R11 sw kept region", {31'd0, probeValid}, 32'd1);
    swLoad(16'h0002);
    chk("R8 sw leaves partial", {29'd0, mode}, 32'd0);

    // R9 pin no longer starts partial refresh
    pinEpisode(20'h00091);
    chk("R9 pin partial blocked", {29'd0, mode}, 32'd0);
    chk("R9 pin load still works", {12'd0, cfgOut}, 32'h91);
    sleepN = 1'b1;
    step(1);
    pinEpisode(20'h00080);
    chk("R9 deep still allowed", {29'd0, mode}, 32'd3);
    sleepN = 1'b1;
    step(RECOV + 2);
    chk("R6 back to active", {29'd0, mode}, 32'd0);

    summary();
    $finish;
  end

endmodule